// File: doc/BRIEF.md
# Burst Framer with Self-Synchronizing Scrambler

This block builds serial transmit bursts for a narrowband FM data link and recovers payload on the receive side. When a burst is requested, the transmit side sends a training run of paired ones and zeros. A programmable 16-bit sync word follows, and then the payload. Only the payload bits are whitened, by a multiplicative scrambler with taps 18 and 23. The preamble and the sync word leave the block unchanged, so a far-end receiver can lock its timing and levels on them.

The receive side is an independent descrambler. It runs on its own bit strobe. Its history register holds received line bits, so it falls into step with any transmitter within 23 bits, and the two ends never need a shared reset. Every transmit action happens only on a cycle where the bit-rate strobe is high. Every receive action happens only on a cycle where the receive strobe is high. Clock recovery, sync-word search and modulation belong to neighbouring blocks.

Top module: `burstFramer`

## Requirements
- R1: After reset, txBit, txActive, payReady and rxData are all 0.
- R2: A one-cycle startBurst while no burst is running arms a burst. The first preamble bit is driven at the next bitStb, and txActive rises at that same edge. A startBurst raised while a burst is running has no effect on the transmitted stream.
- R3: The preamble length is 16 + 4*preSel bits. A preSel value above 12 is treated as 12, giving 64 bits. preSel is sampled only in the cycle of startBurst.
- R4: Preamble bit i (counting from 0) is 1 when i mod 4 is 0 or 1, and 0 otherwise (pattern 1100...).
- R5: After the preamble, the 16-bit syncWord sampled at startBurst is sent MSB first and is not scrambled.
- R6: payReady is 1 only during the payload phase. One payload bit is taken at each bitStb where payValid and payReady are both 1.
- R7: Payload line bit n equals payData XOR line bit n-18 XOR line bit n-23, counting only payload line bits. The scrambler history is cleared to zero at each startBurst.
- R8: A bitStb in the payload phase with payValid low ends the burst. At that edge txActive and txBit go to 0, and payReady is 0 after it.
- R9: txBit and txActive change only at edges where bitStb is 1. rxData changes only at edges where rxStb is 1.
- R10: At each rxStb, rxData becomes rxBit XOR received bit n-18 XOR received bit n-23. Once 23 payload line bits have been received, rxData equals the original payload, whatever came before them.
- R11: A single inverted received bit changes the descrambled output at that bit and again 18 and 23 bits later, and at no other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStb | input | 1 | Transmit bit-rate enable |
| startBurst | input | 1 | One-cycle request to start a burst |
| preSel | input | 4 | Preamble length select, 16 + 4*preSel bits |
| syncWord | input | 16 | Sync word, sent MSB first |
| payValid | input | 1 | Payload bit available |
| payData | input | 1 | Payload bit |
| payReady | output | 1 | Payload phase, bit accepted at bitStb |
| txBit | output | 1 | Serial line bit |
| txActive | output | 1 | Burst on the line |
| rxStb | input | 1 | Receive bit strobe |
| rxBit | input | 1 | Received line bit |
| rxData | output | 1 | Descrambled receive bit |

## Verification
Each line bit and txActive is registered once, so it is due at the same rising edge that carries bitStb. The bench drives the strobe from a falling edge and reads the result at the next falling edge. payReady comes straight from the phase, so it is read before the payload strobe that consumes the bit. rxData is due at the edge carrying rxStb and is sampled half a cycle later. In the strobe-free cycles between bits, the bench toggles payValid and rxBit and confirms that no output moves, and the receive error checks compare two runs that share the same 23-bit prefix.

// File: rtl/burstFramerPkg.sv
package burstFramerPkg;
  localparam int SYNC_W   = 16;
  localparam int PRE_MIN  = 16;
  localparam int PRE_STEP = 4;
  localparam int PRE_MAX  = 64;
  localparam int TAP_NEAR = 18;
  localparam int TAP_FAR  = 23;
  localparam int SEL_MAX  = (PRE_MAX - PRE_MIN) / PRE_STEP;
  localparam int SEL_W    = $clog2(SEL_MAX + 1);
  localparam int CNT_W    = $clog2((PRE_MAX > SYNC_W) ? PRE_MAX : SYNC_W);

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_SYNC, PH_PAY} txPhase_t;

  // strobes from control to datapath; all send* are already qualified by the bit strobe
  typedef struct packed {
    logic clrScr;
    logic loadSync;
    logic sendPre;
    logic preBit;
    logic sendSync;
    logic sendPay;
    logic sendIdle;
  } txCmd_t;
endpackage

// File: rtl/framerCtrl.sv
module framerCtrl
  import burstFramerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStb,
  input  logic             startBurst,
  input  logic [SEL_W-1:0] preSel,
  input  logic             payValid,
  output txCmd_t           cmd,
  output logic             payReady,
  output logic             txActive
);
  txPhase_t         phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] preLast;
  logic [SEL_W-1:0] selLim;
  logic [CNT_W-1:0] preLastNext;

  always_comb begin
    selLim      = (preSel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : preSel;
    preLastNext = CNT_W'(PRE_MIN - 1 + PRE_STEP * int'(selLim));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      preLast  <= '0;
      txActive <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (startBurst) begin
            phase   <= PH_PRE;
            cnt     <= '0;
            preLast <= preLastNext;
          end
        end
        PH_PRE: begin
          if (bitStb) begin
            txActive <= 1'b1;
            if (cnt == preLast) begin
              cnt   <= '0;
              phase <= PH_SYNC;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_SYNC: begin
          if (bitStb) begin
            if (cnt == CNT_W'(SYNC_W - 1)) begin
              cnt   <= '0;
              phase <= PH_PAY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_PAY: begin
          if (bitStb && !payValid) begin
            phase    <= PH_IDLE;
            txActive <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.clrScr   = (phase == PH_IDLE) && startBurst;
    cmd.loadSync = (phase == PH_IDLE) && startBurst;
    cmd.sendPre  = (phase == PH_PRE) && bitStb;
    cmd.preBit   = ~cnt[1];
    cmd.sendSync = (phase == PH_SYNC) && bitStb;
    cmd.sendPay  = (phase == PH_PAY) && bitStb && payValid;
    cmd.sendIdle = (phase == PH_PAY) && bitStb && !payValid;
    payReady     = (phase == PH_PAY);
  end
endmodule

// File: rtl/framerDatapath.sv
module framerDatapath
  import burstFramerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txCmd_t            cmd,
  input  logic [SYNC_W-1:0] syncWord,
  input  logic              payData,
  output logic              txBit
);
  logic [SYNC_W-1:0]  syncSh;
  logic [TAP_FAR-1:0] scrHist;
  logic               scrOut;

  assign scrOut = payData ^ scrHist[TAP_NEAR-1] ^ scrHist[TAP_FAR-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncSh  <= '0;
      scrHist <= '0;
      txBit   <= 1'b0;
    end else begin
      if (cmd.loadSync) syncSh <= syncWord;
      if (cmd.clrScr)   scrHist <= '0;
      if (cmd.sendPre) begin
        txBit <= cmd.preBit;
      end else if (cmd.sendSync) begin
        txBit  <= syncSh[SYNC_W-1];
        syncSh <= {syncSh[SYNC_W-2:0], 1'b0};
      end else if (cmd.sendPay) begin
        txBit   <= scrOut;
        scrHist <= {scrHist[TAP_FAR-2:0], scrOut};
      end else if (cmd.sendIdle) begin
        txBit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxDescrambler.sv
module rxDescrambler
  import burstFramerPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rxStb,
  input  logic rxBit,
  output logic rxData
);
  logic [TAP_FAR-1:0] rxHist;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHist <= '0;
      rxData <= 1'b0;
    end else if (rxStb) begin
      rxData <= rxBit ^ rxHist[TAP_NEAR-1] ^ rxHist[TAP_FAR-1];
      rxHist <= {rxHist[TAP_FAR-2:0], rxBit};
    end
  end
endmodule

// File: rtl/burstFramer.sv
module burstFramer
  import burstFramerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStb,
  input  logic              startBurst,
  input  logic [SEL_W-1:0]  preSel,
  input  logic [SYNC_W-1:0] syncWord,
  input  logic              payValid,
  input  logic              payData,
  output logic              payReady,
  output logic              txBit,
  output logic              txActive,
  input  logic              rxStb,
  input  logic              rxBit,
  output logic              rxData
);
  txCmd_t cmd;

  framerCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .startBurst(startBurst),
    .preSel(preSel), .payValid(payValid), .cmd(cmd),
    .payReady(payReady), .txActive(txActive)
  );

  framerDatapath dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .syncWord(syncWord),
    .payData(payData), .txBit(txBit)
  );

  rxDescrambler rx_i (
    .clk(clk), .rstN(rstN), .rxStb(rxStb), .rxBit(rxBit), .rxData(rxData)
  );
endmodule

// File: rtl/burstFramerChk.sv
module burstFramerChk (
  input logic clk,
  input logic rstN,
  input logic bitStb,
  input logic payValid,
  input logic payReady,
  input logic txBit,
  input logic txActive,
  input logic rxStb,
  input logic rxData
);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitStb |=> ($stable(txActive) && $stable(txBit)));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxStb |=> $stable(rxData));

  // R6
  ready_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    payReady |-> txActive);

  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitStb && payReady && !payValid) |=> (!txActive && !txBit && !payReady));

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> txBit);
endmodule

bind burstFramer burstFramerChk chk_i (
  .clk(clk), .rstN(rstN), .bitStb(bitStb), .payValid(payValid),
  .payReady(payReady), .txBit(txBit), .txActive(txActive),
  .rxStb(rxStb), .rxData(rxData)
);

// File: tb/burstFramer_tb_top.sv
module burstFramer_tb_top;
  localparam int CLK_PERIOD = 10;
  // {preSel[3:0], syncWord[15:0], payload length[7:0], payload pattern[31:0]}
  localparam logic [59:0] VEC [4] = '{
    60'h0_B5C3_28_DEADBEEF,
    60'h3_1ACF_1E_A5F00F5A,
    60'hC_7E81_30_13579BDF,
    60'hF_E4D2_19_FFFF0000
  };
  localparam logic [79:0] STREAM = 80'h9C3A_51E7_0B6D_F284_3CE1;

  logic clk = 1'b0;
  logic rstN, bitStb, startBurst, payValid, payData, payReady;
  logic txBit, txActive, rxStb, rxBit, rxData;
  logic [3:0]  preSel;
  logic [15:0] syncWord;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burstFramer dut_i (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .startBurst(startBurst),
    .preSel(preSel), .syncWord(syncWord), .payValid(payValid),
    .payData(payData), .payReady(payReady), .txBit(txBit),
    .txActive(txActive), .rxStb(rxStb), .rxBit(rxBit), .rxData(rxData)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // idle gap with stability check, then one transmit strobe
  task automatic txStrobe();
    logic b, a;
    b = txBit;
    a = txActive;
    payValid = ~payValid;
    @(negedge clk);
    payValid = ~payValid;
    @(negedge clk);
    check(txBit === b && txActive === a, "R9", {txActive, txBit}, {a, b});
    bitStb = 1'b1;
    @(negedge clk);
    bitStb = 1'b0;
  endtask

  task automatic rxStrobe(input logic b);
    logic h;
    h = rxData;
    rxBit = ~b;
    repeat (2) @(negedge clk);
    check(rxData === h, "R9", rxData, h);
    rxBit = b;
    rxStb = 1'b1;
    @(negedge clk);
    rxStb = 1'b0;
  endtask

  task automatic runBurst(input logic [59:0] v, input bit poke);
    logic [3:0]  sel;
    logic [15:0] sw;
    logic [31:0] pat;
    logic [22:0] scr;
    logic [63:0] rec;
    logic d, e;
    int len, plen;
    sel = v[59:56];
    sw  = v[55:40];
    len = int'(v[39:32]);
    pat = v[31:0];
    plen = 16 + 4 * ((sel > 4'd12) ? 12 : int'(sel));
    preSel = sel;
    syncWord = sw;
    @(negedge clk) startBurst = 1'b1;
    @(negedge clk) startBurst = 1'b0;
    preSel = ~sel;       // R3: only the value at startBurst counts
    syncWord = ~sw;      // R5: only the value at startBurst counts
    @(negedge clk);
    check(txActive === 1'b0, "R2", txActive, 0);
    for (int i = 0; i < plen; i++) begin
      if (poke && i == 5) begin
        startBurst = 1'b1;
        @(negedge clk) startBurst = 1'b0;
      end
      txStrobe();
      check(txActive === 1'b1, "R2", txActive, 1);
      check(txBit === ((i % 4) < 2), "R4", txBit, ((i % 4) < 2));
      check(payReady === 1'b0, "R6", payReady, 0);
    end
    for (int j = 0; j < 16; j++) begin
      txStrobe();
      check(txBit === sw[15-j], (j == 0) ? "R3" : "R5", txBit, sw[15-j]);
    end
    scr = '0;
    rec = '0;
    for (int k = 0; k < len; k++) begin
      d = pat[k % 32];
      payValid = 1'b1;
      payData = d;
      check(payReady === 1'b1, "R6", payReady, 1);
      txStrobe();
      e = d ^ scr[17] ^ scr[22];
      scr = {scr[21:0], e};
      check(txBit === e, "R7", txBit, e);
      rec[k] = txBit;
    end
    payValid = 1'b0;
    payData = 1'b0;
    txStrobe();
    check(txActive === 1'b0 && txBit === 1'b0 && payReady === 1'b0, "R8",
          {txActive, txBit, payReady}, 0);
    for (int k = 0; k < len; k++) begin
      rxStrobe(rec[k]);
      if (k >= 23) check(rxData === pat[k % 32], "R10", rxData, pat[k % 32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [79:0] outA, outB;
    bit expDiff;
    rstN = 1'b0; bitStb = 1'b0; startBurst = 1'b0; payValid = 1'b0;
    payData = 1'b0; rxStb = 1'b0; rxBit = 1'b0;
    preSel = '0; syncWord = '0;
    repeat (3) @(negedge clk);
    // R1
    check(txBit === 1'b0 && txActive === 1'b0 && payReady === 1'b0 && rxData === 1'b0,
          "R1", {txBit, txActive, payReady, rxData}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int e = 0; e < 4; e++) runBurst(VEC[e], (e == 1));

    // R11: two runs sharing a 23-bit prefix, the second with one flipped bit
    for (int n = 0; n < 80; n++) begin
      rxStrobe(STREAM[n]);
      outA[n] = rxData;
    end
    for (int n = 0; n < 80; n++) begin
      rxStrobe((n == 30) ? ~STREAM[n] : STREAM[n]);
      outB[n] = rxData;
    end
    for (int n = 23; n < 80; n++) begin
      expDiff = (n == 30) || (n == 48) || (n == 53);
      check((outA[n] ^ outB[n]) === expDiff, "R11", outA[n] ^ outB[n], expDiff);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule